// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which DMA channel the transfer engine serves next. Each of its channels can ask for service in two ways: through a hardware request line driven by a peripheral, or through a software start bit that is set by a one-cycle pulse. Both kinds of request pass through the same register stage. Arbitration then runs on the registered values in the following cycle. The block hands one winning channel number to the address path, together with a one-cycle valid strobe.

A configuration input picks the selection policy while the block runs. Fixed priority always favours the highest-numbered pending channel. Round robin starts its search at the channel just after the previous winner and wraps around. A per-channel enable mask filters hardware requests only, so software starts always get through. After it issues a grant, the arbiter stops issuing further grants until the engine reports that it is no longer busy. The software start bit of the winning channel is cleared at the moment the grant is taken.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0, all `sw_pending` bits are 0, and the round-robin search begins at channel 0.
- R2: A hardware request that is high and enabled at clock edge k is registered at edge k. The grant for it appears as `grant_valid` = 1 after edge k+1, with `grant_ch` holding the channel index as an unsigned binary number.
- R3: A `sw_set[i]` pulse sampled at edge k sets `sw_pending[i]` at that edge. The channel is then granted after edge k+1, which is the same latency a hardware request has.
- R4: When `en_mask[i]` is 0, a hardware request on channel i never produces a grant. A software start on channel i is still granted.
- R5: When `rr_mode` = 0, the grant goes to the highest-numbered channel that has an enabled hardware request or a set software bit.
- R6: When `rr_mode` = 1, the grant goes to the first pending channel found by searching upward from the last winner plus one, wrapping from N-1 back to 0.
- R7: `grant_valid` lasts exactly one cycle for each grant. Every granted channel was pending in the arbitration cycle.
- R8: After a grant, no new grant is issued in the cycle that follows. No grant is issued while `eng_busy` is sampled high. After a cycle in which `eng_busy` is sampled low, arbitration resumes in the next cycle.
- R9: A granted channel's software bit is cleared at the grant edge. If a `sw_set` for the same channel is sampled at that same edge, the bit stays set.
- R10: `rr_mode` takes effect in the arbitration cycle, so the policy can be changed between grants without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 1 = round robin, 0 = fixed priority (highest channel wins) |
| en_mask | input | NUM_CH | Per-channel enable for hardware requests |
| hw_req | input | NUM_CH | Peripheral request lines |
| sw_set | input | NUM_CH | Pulses that set the software start bits |
| eng_busy | input | 1 | The engine is servicing the granted channel |
| grant_valid | output | 1 | One-cycle strobe marking a new winner |
| grant_ch | output | CH_W | Number of the winning channel |
| sw_pending | output | NUM_CH | Current software start bits |

## Verification
Two events can land on the same clock edge: a new software start for a channel, and the grant that clears that channel's start bit. The bench provokes this by holding `sw_set` on one channel across both the registration edge and the grant edge. It then expects the grant and a start bit that is still set, followed by a second grant of the same channel that finally clears the bit. A second overlap comes from an engine that raises `eng_busy` while requests remain pending. The bench confirms that no grant appears for several cycles and that the next grant comes exactly two edges after busy drops.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_SERVE = 1'b1
  } arb_state_t;
endpackage

// File: rtl/arb_req_capture.sv
module arb_req_capture #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_req,
  input  logic [N-1:0] en_mask,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] sw_pend,
  output logic [N-1:0] req_eff
);
  logic [N-1:0] hw_q;

  // Both request sources land in flops; arbitration sees only registered values.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_q    <= '0;
      sw_pend <= '0;
    end else begin
      hw_q    <= hw_req;
      sw_pend <= (sw_pend & ~clr_vec) | sw_set;  // a new start beats the grant clear
    end
  end

  // The enable mask filters hardware requests only.
  assign req_eff = (hw_q & en_mask) | sw_pend;
endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] req_eff,
  input  logic [W-1:0] last_ch,
  input  logic         rr_mode,
  output logic         any_req,
  output logic [W-1:0] win_ch
);
  // Highest index that is set wins.
  function automatic logic [W-1:0] pick_fixed(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) r = W'(i);
    end
    return r;
  endfunction

  // First set index after 'last', wrapping; 'last' itself is examined last.
  function automatic logic [W-1:0] pick_rr(input logic [N-1:0] v,
                                           input logic [W-1:0] last);
    logic [W-1:0] r;
    logic         hit;
    int           idx;
    r   = '0;
    hit = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!hit && v[W'(idx)]) begin
        r   = W'(idx);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic [W-1:0] fixed_ch;
  logic [W-1:0] rr_ch;

  assign fixed_ch = pick_fixed(req_eff);
  assign rr_ch    = pick_rr(req_eff, last_ch);
  assign any_req  = |req_eff;
  assign win_ch   = rr_mode ? rr_ch : fixed_ch;
endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl
  import dma_arb_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         any_req,
  input  logic [W-1:0] win_ch,
  input  logic         eng_busy,
  output logic         take,
  output logic         serving,
  output logic [N-1:0] clr_vec,
  output logic [W-1:0] last_ch,
  output logic         grant_valid,
  output logic [W-1:0] grant_ch
);
  arb_state_t state_q;

  assign serving = (state_q == ARB_SERVE);
  assign take    = (state_q == ARB_IDLE) && any_req;

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[win_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ARB_IDLE;
      grant_valid <= 1'b0;
      grant_ch    <= '0;
      last_ch     <= W'(N - 1);
    end else begin
      grant_valid <= take;
      if (take) begin
        grant_ch <= win_ch;
        last_ch  <= win_ch;
      end
      case (state_q)
        ARB_IDLE:  if (take) state_q <= ARB_SERVE;
        ARB_SERVE: if (!eng_busy) state_q <= ARB_IDLE;
        default:   state_q <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rr_mode,
  input  logic [NUM_CH-1:0] en_mask,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_set,
  input  logic              eng_busy,
  output logic              grant_valid,
  output logic [CH_W-1:0]   grant_ch,
  output logic [NUM_CH-1:0] sw_pending
);
  // Named internal events for the checker.
  logic [NUM_CH-1:0] req_eff;
  logic [NUM_CH-1:0] clr_vec;
  logic              any_req;
  logic              take;
  logic              serving;
  logic [CH_W-1:0]   win_ch;
  logic [CH_W-1:0]   last_ch;

  arb_req_capture #(.N(NUM_CH)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_req  (hw_req),
    .en_mask (en_mask),
    .sw_set  (sw_set),
    .clr_vec (clr_vec),
    .sw_pend (sw_pending),
    .req_eff (req_eff)
  );

  arb_select #(.N(NUM_CH), .W(CH_W)) u_sel (
    .req_eff (req_eff),
    .last_ch (last_ch),
    .rr_mode (rr_mode),
    .any_req (any_req),
    .win_ch  (win_ch)
  );

  arb_grant_ctrl #(.N(NUM_CH), .W(CH_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_req     (any_req),
    .win_ch      (win_ch),
    .eng_busy    (eng_busy),
    .take        (take),
    .serving     (serving),
    .clr_vec     (clr_vec),
    .last_ch     (last_ch),
    .grant_valid (grant_valid),
    .grant_ch    (grant_ch)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N = 16,
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         grant_valid,
  input logic [W-1:0] grant_ch,
  input logic         eng_busy,
  input logic         rr_mode,
  input logic [N-1:0] sw_set,
  input logic [N-1:0] sw_pending,
  input logic [N-1:0] req_eff,
  input logic         serving,
  input logic [W-1:0] last_ch
);
  logic [N-1:0] req_prev;
  logic [N-1:0] set_prev;
  logic         rr_prev;
  logic [W-1:0] last_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_prev  <= '0;
      set_prev  <= '0;
      rr_prev   <= 1'b0;
      last_prev <= W'(N - 1);
    end else begin
      req_prev  <= req_eff;
      set_prev  <= sw_set;
      rr_prev   <= rr_mode;
      last_prev <= last_ch;
    end
  end

  logic higher_pending;
  logic rr_skipped;
  always_comb begin
    higher_pending = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (i > int'(grant_ch) && req_prev[i]) higher_pending = 1'b1;
    end
  end

  always_comb begin
    int  idx;
    logic reached;
    rr_skipped = 1'b0;
    reached    = 1'b0;
    for (int k = 1; k < N; k++) begin
      idx = (int'(last_prev) + k) % N;
      if (idx == int'(grant_ch)) reached = 1'b1;
      if (!reached && req_prev[W'(idx)]) rr_skipped = 1'b1;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> !grant_valid);

  a_r7_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> req_prev[grant_ch]);

  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && eng_busy) |=> !grant_valid);

  a_r5_fixed_highest: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !rr_prev) |-> !higher_pending);

  a_r6_rr_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && rr_prev) |-> !rr_skipped);

  a_r9_sw_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !set_prev[grant_ch]) |-> !sw_pending[grant_ch]);
endmodule

bind dma_req_arbiter arb_checker #(.N(NUM_CH), .W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant_valid (grant_valid),
  .grant_ch    (grant_ch),
  .eng_busy    (eng_busy),
  .rr_mode     (rr_mode),
  .sw_set      (sw_set),
  .sw_pending  (sw_pending),
  .req_eff     (req_eff),
  .serving     (serving),
  .last_ch     (last_ch)
);

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         rr_mode;
  logic [N-1:0] en_mask;
  logic [N-1:0] hw_req;
  logic [N-1:0] sw_set;
  logic         eng_busy;
  logic         grant_valid;
  logic [3:0]   grant_ch;
  logic [N-1:0] sw_pending;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dma_req_arbiter #(.NUM_CH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .en_mask(en_mask),
    .hw_req(hw_req), .sw_set(sw_set), .eng_busy(eng_busy),
    .grant_valid(grant_valid), .grant_ch(grant_ch), .sw_pending(sw_pending)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gval();
    return grant_valid ? int'(grant_ch) : -1;
  endfunction

  task automatic finish_report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hw_req = '0; sw_set = '0; eng_busy = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive hw_req at a negedge, then sample at the negedge after the second edge.
  task automatic hw_grant(input logic [N-1:0] v, input int exp, input string tag);
    @(negedge clk);
    hw_req = v;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(grant_valid && int'(grant_ch) == exp, tag, gval(), exp);
    hw_req = '0;
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_report();
  end

  initial begin
    rst_n = 1'b0; rr_mode = 1'b0; en_mask = '1; hw_req = '0; sw_set = '0; eng_busy = 1'b0;
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk(grant_valid == 1'b0, "R1 grant_valid", int'(grant_valid), 0);
    chk(sw_pending == '0, "R1 sw_pending", int'(sw_pending), 0);

    // R1/R6: first round-robin search starts at channel 0
    rr_mode = 1'b1;
    hw_grant(16'h8001, 0, "R1 rr start");
    rr_mode = 1'b0;

    // R2/R5: fixed priority, every pair of channels
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        hw_grant(N'(1) << i | N'(1) << j, j, "R5 fixed pair");
    hw_grant(16'h0010, 4, "R2 single latency");

    // R6: round robin, every last winner against every pair
    rr_mode = 1'b1;
    for (int l = 0; l < N; l++)
      for (int a = 0; a < N; a++)
        for (int b = a + 1; b < N; b++) begin
          int da;
          int db;
          hw_grant(N'(1) << l, l, "R6 set last");
          da = (a - l - 1 + 2 * N) % N;
          db = (b - l - 1 + 2 * N) % N;
          hw_grant(N'(1) << a | N'(1) << b, (da < db) ? a : b, "R6 rr pair");
        end

    // R10: policy switch at runtime
    do_reset();
    rr_mode = 1'b0;
    hw_grant(16'h0204, 9, "R10 fixed picks 9");
    rr_mode = 1'b1;
    hw_grant(16'h0204, 2, "R10 rr after 9 picks 2");
    rr_mode = 1'b0;

    // R4: masked hardware request never granted
    en_mask = ~(N'(1) << 5);
    @(negedge clk);
    hw_req = N'(1) << 5;
    repeat (4) begin
      @(posedge clk); @(negedge clk);
      chk(!grant_valid, "R4 masked hw", gval(), -1);
    end
    hw_req = '0;
    // R3/R4: software start on masked channel, same latency
    @(negedge clk);
    sw_set = N'(1) << 5;
    @(posedge clk); @(negedge clk);
    sw_set = '0;
    chk(sw_pending[5], "R3 sw bit set", int'(sw_pending[5]), 1);
    @(posedge clk); @(negedge clk);
    chk(grant_valid && grant_ch == 4'd5, "R4 sw bypasses mask", gval(), 5);
    chk(!sw_pending[5], "R9 sw cleared", int'(sw_pending[5]), 0);
    en_mask = '1;
    @(posedge clk);

    // R9: set and clear on the same edge
    @(negedge clk);
    sw_set = N'(1) << 3;
    @(posedge clk); @(posedge clk); @(negedge clk);
    sw_set = '0;
    chk(grant_valid && grant_ch == 4'd3, "R9 first grant", gval(), 3);
    chk(sw_pending[3], "R9 set wins over clear", int'(sw_pending[3]), 1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(grant_valid && grant_ch == 4'd3, "R9 second grant", gval(), 3);
    chk(!sw_pending[3], "R9 cleared after second", int'(sw_pending[3]), 0);
    @(posedge clk);

    // R7/R8: busy holds off new grants
    @(negedge clk);
    hw_req = N'(1) << 7;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(grant_valid && grant_ch == 4'd7, "R8 grant before busy", gval(), 7);
    eng_busy = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!grant_valid, "R7 one-cycle strobe", gval(), -1);
    repeat (5) begin
      @(posedge clk); @(negedge clk);
      chk(!grant_valid, "R8 no grant while busy", gval(), -1);
    end
    eng_busy = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!grant_valid, "R8 leave serve", gval(), -1);
    @(posedge clk); @(negedge clk);
    chk(grant_valid && grant_ch == 4'd7, "R8 resume after busy", gval(), 7);
    hw_req = '0;
    @(posedge clk); @(negedge clk);
    chk(!grant_valid, "R7 pulse ends", gval(), -1);

    finish_report();
  end
endmodule